// File: doc/BRIEF.md
# Operand Shifter with Shift Carry

This block forms the second operand of a processor datapath. It takes a 32-bit register value and shifts or rotates it by an amount that comes from a 5-bit field of the instruction or from the whole low byte of another register. It can also build a constant by rotating an 8-bit value right by twice a 4-bit field. Along with the value it produces the shifter carry, which is the last bit shifted out, so that a flag-setting logical instruction can update its carry flag.

The shifter core is a chain of five 2-input multiplexer stages that rotate right only. A left shift first rotates the operand right by one place and then rotates it right by the complement of the amount. A per-bit fill stage then replaces the vacated positions with zero or with the sign bit. The result and the carry are registered once. Both outputs are valid on the clock edge that follows the inputs.

Top module: `barrel_shift_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `result_q` and `carry_q` become zero. Otherwise both outputs take the value computed from the inputs present at that edge, one clock after those inputs were applied.
- R2: Code `op_sel`=0 (shift left) moves the operand left by k with zeros entering at bit 0. For 1 ≤ k ≤ 31 the carry is operand bit 32−k.
- R3: Code 1 (logical right shift) moves the operand right by k with zeros entering at bit 31. For 1 ≤ k ≤ 31 the carry is operand bit k−1.
- R4: Code 2 (arithmetic right shift) moves the operand right by k and copies bit 31 into the vacated positions. For 1 ≤ k ≤ 31 the carry is operand bit k−1.
- R5: Code 3 (rotate right) with a non-zero amount wraps the bits that leave bit 0 into bit 31. The carry equals bit 31 of the result.
- R6: Code 3 with `amt_from_reg`=0 and `shamt_imm`=0 rotates right by exactly one place through the carry. The result is {`carry_in`, operand[31:1]} and the carry is operand[0].
- R7: With `amt_from_reg`=0 the amount is `shamt_imm` and `reg_amt` is ignored. With `amt_from_reg`=1 the amount is all 8 bits of `reg_amt` and `shamt_imm` is ignored.
- R8: An amount of zero passes the operand through unchanged, with `carry_in` as the carry. This holds for codes 0–2 from either source, and for code 3 from the register source.
- R9: A register amount of 32 or more behaves as follows. Codes 0 and 1 give zero. The carry is operand[0] (code 0) or operand[31] (code 1) when the amount is exactly 32, and zero above 32. Code 2 gives 32 copies of operand[31] with that bit as the carry. Code 3 rotates by the amount modulo 32.
- R10: Code 4 returns `imm_val`, zero-extended to 32 bits and rotated right by 2×`imm_rot`. The carry is `carry_in` when `imm_rot` is 0 and bit 31 of the result otherwise.
- R11: Codes 5, 6 and 7 pass the operand through unchanged, with `carry_in` as the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 3 | Operation code (0 LSL, 1 LSR, 2 ASR, 3 ROR/RRX, 4 immediate) |
| amt_from_reg | input | 1 | 1: amount from `reg_amt`; 0: from `shamt_imm` |
| shamt_imm | input | 5 | Instruction-field shift amount |
| reg_amt | input | 8 | Register low byte used as shift amount |
| operand | input | 32 | Value to shift |
| carry_in | input | 1 | Current carry flag |
| imm_val | input | 8 | Constant for immediate mode |
| imm_rot | input | 4 | Half the rotate amount for immediate mode |
| result_q | output | 32 | Registered shifted value |
| carry_q | output | 1 | Registered shifter carry |

## Verification
In a single cycle the block can rotate the operand and also pull the incoming carry into bit 31. It can likewise saturate a large register amount and still pick the carry from a boundary bit. The bench provokes the first case with the one-place rotate through carry, using both values of `carry_in` on an operand whose bit 0 is set. It judges both outputs against hand-worked vectors. It provokes the second case with register amounts of exactly 32, just above 32, and far above 32. The checker also compares the registered outputs against the inputs of the previous cycle.

// File: rtl/bsh_pkg.sv
// Shared definitions for the operand shifter.
// Assumes a power-of-two data width.
package bsh_pkg;
    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_IMM = 3'd4
    } shift_op_e;
endpackage

// File: rtl/bsh_amount_sel.sv
// Chooses the shift amount source and classifies the amount.
// Assumes REG_W > AMT_W; the data width is 2**AMT_W.
module bsh_amount_sel #(
    parameter int AMT_W = 5,
    parameter int REG_W = 8
) (
    input  logic             from_reg,
    input  logic [AMT_W-1:0] shamt_imm,
    input  logic [REG_W-1:0] reg_amt,
    output logic [AMT_W-1:0] amt_low,
    output logic             amt_zero,
    output logic             amt_ge_w,
    output logic             amt_eq_w
);
    localparam int W = 1 << AMT_W;

    // Select the source and flag zero, >= width and == width.
    always_comb begin
        if (from_reg) begin
            amt_low  = reg_amt[AMT_W-1:0];
            amt_zero = (reg_amt == '0);
            amt_ge_w = |reg_amt[REG_W-1:AMT_W];
            amt_eq_w = (reg_amt == REG_W'(W));
        end else begin
            amt_low  = shamt_imm;
            amt_zero = (shamt_imm == '0);
            amt_ge_w = 1'b0;
            amt_eq_w = 1'b0;
        end
    end
endmodule

// File: rtl/bsh_rot_stages.sv
// Logarithmic right rotator: one 2-input mux stage per amount bit.
// Assumes W is a power of two.
module bsh_rot_stages #(
    parameter int W = 32,
    localparam int LW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [LW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [LW+1];

    assign stg[0] = din;

    for (genvar s = 0; s < LW; s++) begin : g_stage
        localparam int D = 1 << s;
        // Rotate right by 2**s when this amount bit is set.
        assign stg[s+1] = amt[s] ? {stg[s][D-1:0], stg[s][W-1:D]} : stg[s];
    end

    assign dout = stg[LW];
endmodule

// File: rtl/bsh_mask_fill.sv
// Replaces vacated positions of a rotated word with a fill bit.
// Assumes k in 1..W-1 whenever the mask matters.
module bsh_mask_fill #(
    parameter int W = 32,
    localparam int LW = $clog2(W)
) (
    input  logic [W-1:0]  rotated,
    input  logic [LW-1:0] k,
    input  logic          left,
    input  logic          fill_bit,
    output logic [W-1:0]  shifted
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic vacated;
        // Left shifts vacate low bits; right shifts vacate high bits.
        assign vacated    = left ? (i < int'(k)) : ((i + int'(k)) >= W);
        assign shifted[i] = vacated ? fill_bit : rotated[i];
    end
endmodule

// File: rtl/barrel_shift_unit.sv
// Second-operand shifter with shift carry and a registered output.
// Assumes DATA_W == 2**SH_W and ROT_W + 1 == SH_W.
module barrel_shift_unit
    import bsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5,
    parameter int REG_W  = 8,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic              amt_from_reg,
    input  logic [SH_W-1:0]   shamt_imm,
    input  logic [REG_W-1:0]  reg_amt,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic [ROT_W-1:0]  imm_rot,
    output logic [DATA_W-1:0] result_q,
    output logic              carry_q
);
    localparam int W = DATA_W;

    shift_op_e       op;
    logic [SH_W-1:0] k;
    logic            k_zero, k_ge_w, k_eq_w;
    logic            is_left;
    logic [W-1:0]    rot_in, rot_out, masked;
    logic [SH_W-1:0] rot_amt, carry_idx, imm_amt;
    logic [W-1:0]    imm_out;
    logic            sign;
    logic [W-1:0]    nxt_res;
    logic            nxt_c;

    assign op      = shift_op_e'(op_sel);
    assign sign    = operand[W-1];
    assign is_left = (op == SH_LSL);

    bsh_amount_sel #(.AMT_W(SH_W), .REG_W(REG_W)) u_amt (
        .from_reg (amt_from_reg),
        .shamt_imm(shamt_imm),
        .reg_amt  (reg_amt),
        .amt_low  (k),
        .amt_zero (k_zero),
        .amt_ge_w (k_ge_w),
        .amt_eq_w (k_eq_w)
    );

    // Left by k is a one-place pre-rotate then a right rotate by ~k.
    always_comb begin
        rot_in    = is_left ? {operand[0], operand[W-1:1]} : operand;
        rot_amt   = is_left ? ~k : k;
        carry_idx = is_left ? (~k + 1'b1) : (k - 1'b1);
        imm_amt   = SH_W'({imm_rot, 1'b0});
    end

    bsh_rot_stages #(.W(W)) u_main_rot (
        .din (rot_in),
        .amt (rot_amt),
        .dout(rot_out)
    );

    bsh_mask_fill #(.W(W)) u_fill (
        .rotated (rot_out),
        .k       (k),
        .left    (is_left),
        .fill_bit((op == SH_ASR) & sign),
        .shifted (masked)
    );

    bsh_rot_stages #(.W(W)) u_imm_rot (
        .din ({{(W-IMM_W){1'b0}}, imm_val}),
        .amt (imm_amt),
        .dout(imm_out)
    );

    // Select the result and carry for the requested operation.
    always_comb begin
        nxt_res = operand;
        nxt_c   = carry_in;
        case (op)
            SH_LSL, SH_LSR: begin
                if (k_zero) begin
                    nxt_res = operand;
                    nxt_c   = carry_in;
                end else if (k_ge_w) begin
                    nxt_res = '0;
                    nxt_c   = k_eq_w & (is_left ? operand[0] : sign);
                end else begin
                    nxt_res = masked;
                    nxt_c   = operand[carry_idx];
                end
            end
            SH_ASR: begin
                if (k_zero) begin
                    nxt_res = operand;
                    nxt_c   = carry_in;
                end else if (k_ge_w) begin
                    nxt_res = {W{sign}};
                    nxt_c   = sign;
                end else begin
                    nxt_res = masked;
                    nxt_c   = operand[carry_idx];
                end
            end
            SH_ROR: begin
                if (k_zero && !amt_from_reg) begin
                    nxt_res = {carry_in, operand[W-1:1]};
                    nxt_c   = operand[0];
                end else if (k_zero) begin
                    nxt_res = operand;
                    nxt_c   = carry_in;
                end else begin
                    nxt_res = rot_out;
                    nxt_c   = rot_out[W-1];
                end
            end
            SH_IMM: begin
                nxt_res = imm_out;
                nxt_c   = (imm_rot == '0) ? carry_in : imm_out[W-1];
            end
            default: begin
                nxt_res = operand;
                nxt_c   = carry_in;
            end
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            carry_q  <= 1'b0;
        end else begin
            result_q <= nxt_res;
            carry_q  <= nxt_c;
        end
    end
endmodule

// File: rtl/barrel_shift_unit_chk.sv
// Property checker for the operand shifter, bound to every instance.
// Assumes the one-cycle output latency of the top module.
module barrel_shift_unit_chk #(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5,
    parameter int REG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_sel,
    input logic              amt_from_reg,
    input logic [SH_W-1:0]   shamt_imm,
    input logic [REG_W-1:0]  reg_amt,
    input logic [DATA_W-1:0] operand,
    input logic              carry_in,
    input logic [DATA_W-1:0] result_q,
    input logic              carry_q
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !$past(rst_n) |-> (result_q == '0 && !carry_q)); // R1

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && amt_from_reg && reg_amt == '0 && op_sel <= 3'd3)
        |-> (result_q == $past(operand) && carry_q == $past(carry_in))); // R8

    AST_RRX_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && op_sel == 3'd3 && !amt_from_reg && shamt_imm == '0)
        |-> (result_q == {$past(carry_in), $past(operand[DATA_W-1:1])}
             && carry_q == $past(operand[0]))); // R6

    AST_BIG_LOGICAL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && amt_from_reg && reg_amt > REG_W'(DATA_W) && op_sel <= 3'd1)
        |-> (result_q == '0 && !carry_q)); // R9

    AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && op_sel == 3'd3
              && (amt_from_reg ? reg_amt != '0 : shamt_imm != '0))
        |-> (carry_q == result_q[DATA_W-1])); // R5

    AST_SPARE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && op_sel > 3'd4)
        |-> (result_q == $past(operand) && carry_q == $past(carry_in))); // R11
endmodule

bind barrel_shift_unit barrel_shift_unit_chk #(
    .DATA_W(DATA_W), .SH_W(SH_W), .REG_W(REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_sel      (op_sel),
    .amt_from_reg(amt_from_reg),
    .shamt_imm   (shamt_imm),
    .reg_amt     (reg_amt),
    .operand     (operand),
    .carry_in    (carry_in),
    .result_q    (result_q),
    .carry_q     (carry_q)
);

// File: tb/barrel_shift_unit_bench.sv
// Vector-table bench for the operand shifter; 250 MHz clock (4 time units).
module barrel_shift_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        amt_from_reg = 1'b0;
    logic [4:0]  shamt_imm = '0;
    logic [7:0]  reg_amt = '0;
    logic [31:0] operand = '0;
    logic        carry_in = 1'b0;
    logic [7:0]  imm_val = '0;
    logic [3:0]  imm_rot = '0;
    logic [31:0] result_q;
    logic        carry_q;

    int checks = 0;
    int fails  = 0;

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  op;
        logic        src;
        logic [4:0]  sh;
        logic [7:0]  ramt;
        logic [31:0] opnd;
        logic        cin;
        logic [7:0]  imm;
        logic [3:0]  rot;
        logic [31:0] res;
        logic        c;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TV [NV] = '{
        '{8'd2,  3'd0, 1'b0, 5'd4,  8'd200, 32'hF000000B, 1'b0, 8'h00, 4'd0, 32'h000000B0, 1'b1}, // R2, R7
        '{8'd3,  3'd1, 1'b0, 5'd4,  8'd0,   32'hF000000B, 1'b0, 8'h00, 4'd0, 32'h0F000000, 1'b1}, // R3
        '{8'd4,  3'd2, 1'b0, 5'd4,  8'd0,   32'hF000000B, 1'b0, 8'h00, 4'd0, 32'hFF000000, 1'b1}, // R4
        '{8'd5,  3'd3, 1'b0, 5'd4,  8'd0,   32'hF000000B, 1'b0, 8'h00, 4'd0, 32'hBF000000, 1'b1}, // R5
        '{8'd6,  3'd3, 1'b0, 5'd0,  8'd9,   32'hF000000B, 1'b0, 8'h00, 4'd0, 32'h78000005, 1'b1}, // R6
        '{8'd6,  3'd3, 1'b0, 5'd0,  8'd0,   32'hF000000B, 1'b1, 8'h00, 4'd0, 32'hF8000005, 1'b1}, // R6
        '{8'd9,  3'd0, 1'b1, 5'd3,  8'd32,  32'hF000000B, 1'b0, 8'h00, 4'd0, 32'h00000000, 1'b1}, // R9
        '{8'd9,  3'd0, 1'b1, 5'd0,  8'd33,  32'hF000000B, 1'b1, 8'h00, 4'd0, 32'h00000000, 1'b0}, // R9
        '{8'd9,  3'd1, 1'b1, 5'd0,  8'd32,  32'hF000000B, 1'b0, 8'h00, 4'd0, 32'h00000000, 1'b1}, // R9
        '{8'd9,  3'd2, 1'b1, 5'd0,  8'd200, 32'hF000000B, 1'b0, 8'h00, 4'd0, 32'hFFFFFFFF, 1'b1}, // R9
        '{8'd7,  3'd3, 1'b1, 5'd1,  8'd36,  32'hF000000B, 1'b0, 8'h00, 4'd0, 32'hBF000000, 1'b1}, // R7, R9
        '{8'd9,  3'd3, 1'b1, 5'd0,  8'd64,  32'hF000000B, 1'b0, 8'h00, 4'd0, 32'hF000000B, 1'b1}, // R9
        '{8'd8,  3'd0, 1'b1, 5'd7,  8'd0,   32'hF000000B, 1'b1, 8'h00, 4'd0, 32'hF000000B, 1'b1}, // R8
        '{8'd8,  3'd3, 1'b1, 5'd0,  8'd0,   32'hF000000B, 1'b0, 8'h00, 4'd0, 32'hF000000B, 1'b0}, // R8
        '{8'd8,  3'd1, 1'b0, 5'd0,  8'd5,   32'hF000000B, 1'b1, 8'h00, 4'd0, 32'hF000000B, 1'b1}, // R8
        '{8'd10, 3'd4, 1'b0, 5'd0,  8'd0,   32'h00000000, 1'b0, 8'hAB, 4'd4, 32'hAB000000, 1'b1}, // R10
        '{8'd10, 3'd4, 1'b0, 5'd3,  8'd0,   32'hFFFFFFFF, 1'b0, 8'hAB, 4'd0, 32'h000000AB, 1'b0}, // R10
        '{8'd10, 3'd4, 1'b0, 5'd0,  8'd0,   32'h00000000, 1'b0, 8'hFF, 4'd1, 32'hC000003F, 1'b1}, // R10
        '{8'd3,  3'd1, 1'b1, 5'd0,  8'd1,   32'hF000000B, 1'b0, 8'h00, 4'd0, 32'h78000005, 1'b1}, // R3, R7
        '{8'd4,  3'd2, 1'b0, 5'd31, 8'd0,   32'h70000000, 1'b0, 8'h00, 4'd0, 32'h00000000, 1'b1}, // R4
        '{8'd2,  3'd0, 1'b0, 5'd31, 8'd0,   32'h00000003, 1'b0, 8'h00, 4'd0, 32'h80000000, 1'b1}, // R2
        '{8'd4,  3'd2, 1'b0, 5'd5,  8'd0,   32'hFFFFFFC0, 1'b1, 8'h00, 4'd0, 32'hFFFFFFFE, 1'b0}, // R4
        '{8'd11, 3'd6, 1'b1, 5'd9,  8'd9,   32'h12345678, 1'b1, 8'h55, 4'd3, 32'h12345678, 1'b1}  // R11
    };

    barrel_shift_unit u_barrel_shift_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_sel      (op_sel),
        .amt_from_reg(amt_from_reg),
        .shamt_imm   (shamt_imm),
        .reg_amt     (reg_amt),
        .operand     (operand),
        .carry_in    (carry_in),
        .imm_val     (imm_val),
        .imm_rot     (imm_rot),
        .result_q    (result_q),
        .carry_q     (carry_q)
    );

    always #2 clk = ~clk;

    task automatic check(input int req, input logic [31:0] exp_r, input logic exp_c);
        checks++;
        if (result_q !== exp_r || carry_q !== exp_c) begin
            fails++;
            $display("FAIL R%0d: result=%h carry=%b expected result=%h carry=%b",
                     req, result_q, carry_q, exp_r, exp_c);
        end
    endtask

    task automatic apply(input vec_t v);
        op_sel       = v.op;
        amt_from_reg = v.src;
        shamt_imm    = v.sh;
        reg_amt      = v.ramt;
        operand      = v.opnd;
        carry_in     = v.cin;
        imm_val      = v.imm;
        imm_rot      = v.rot;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1: watchdog expired, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: outputs clear while reset is held, even with live inputs.
        apply(TV[0]);
        repeat (2) @(negedge clk);
        check(1, 32'h0, 1'b0);
        rst_n = 1'b1;

        // Table walk: apply at a falling edge, sample at the next one.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(TV[i]);
            @(negedge clk);
            check(int'(TV[i].req), TV[i].res, TV[i].c);
        end

        // R1: a mid-run reset clears a non-zero result.
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check(11, 32'h12345678, 1'b1);

        // R8: immediate zero shift on the left path keeps carry_in = 0.
        apply('{8'd8, 3'd0, 1'b0, 5'd0, 8'd40, 32'hA5A5A5A5, 1'b0, 8'h00, 4'd0, 32'h0, 1'b0});
        @(negedge clk);
        check(8, 32'hA5A5A5A5, 1'b0);

        // R9: right shift by 33 from a register gives zero with no carry.
        apply('{8'd9, 3'd1, 1'b1, 5'd0, 8'd33, 32'hFFFFFFFF, 1'b1, 8'h00, 4'd0, 32'h0, 1'b0});
        @(negedge clk);
        check(9, 32'h0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule